// File: doc/BRIEF.md
# Three-Level Haar Wavelet Packet Engine

This block performs a full three-level wavelet packet decomposition on a stream of signed samples, using two-tap Haar filters. Each filter forms the average of an even/odd sample pair and half of their difference. Unlike a plain wavelet pyramid, the block splits the high band again at every level as well as the low band. Every group of eight input samples therefore yields one coefficient in each of eight sub-bands.

Samples arrive through a valid/ready handshake at up to one per cycle. A start-of-frame flag forces pairing to restart, and a last flag marks the final sample of a frame. Level one is a single pair stage. Level two is two pair stages running side by side. Their four outputs are captured in a register bank. A 4-way selector then feeds one band per cycle to a single shared level-three filter.

Each output cycle presents the low and the high coefficient of one level-two band. Each coefficient carries a 3-bit sub-band tag. The 1/2 scaling is a one-digit canonic-signed-digit term, so it is a plain wire shift: the block has no multiplier and no sample memory.

Top module: `wpt_haar3`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, out_eof and in_ready are low after that edge. in_ready is high after the first edge with rst_n high.
- R2: For every pair, the first sample accepted is the even sample a and the next one is the odd sample b. The low result is floor((a+b)/2) and the high result is floor((a-b)/2), both computed one bit wider than the data.
- R3: Every complete group of eight accepted samples produces exactly eight level-three coefficients. Each one equals the Haar cascade of R2 applied through all three levels with both bands split at each level.
- R4: Tag bit 2 is the level-1 band, tag bit 1 is the level-2 band and tag bit 0 is the level-3 band, with 0 meaning low and 1 meaning high. out_lo_tag always has bit 0 = 0 and out_hi_tag always has bit 0 = 1.
- R5: Each group's output appears on four consecutive out_valid cycles. The level-2 band selector (tag[2:1]) runs 00, 01, 10, 11 in that order.
- R6: Let E be the clock edge that accepts the eighth sample of a group. The coefficients of band selector s are registered at edge E+3+s.
- R7: An accepted sample with in_sof high is taken as the even sample at every level. A partial group cut off by in_sof produces no output.
- R8: out_eof pulses for exactly one cycle, registered at edge E+7, where E accepts the sample that carried in_last. It therefore comes after all eight coefficients of that group.
- R9: Cycles with in_valid low are ignored whatever in_data holds. Gaps do not change the coefficient values or the timing of R6.
- R10: Full-scale inputs, including the most positive and most negative values, produce results without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_sof | input | 1 | Sample is the first of a frame |
| in_last | input | 1 | Sample is the last of a frame |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Coefficient pair valid |
| out_lo_data | output | DATA_W | Level-3 low coefficient |
| out_lo_tag | output | 3 | Sub-band tag of out_lo_data |
| out_hi_data | output | DATA_W | Level-3 high coefficient |
| out_hi_tag | output | 3 | Sub-band tag of out_hi_data |
| out_eof | output | 1 | End-of-frame strobe |

## Verification
The bench counts clock edges. For each group it records the edge E at which the eighth sample was accepted, and expects band selector s at edge E+3+s and the frame strobe at E+7. Outputs are sampled on the falling edge and logged together with the edge count. Each logged edge, tag and value is compared in order against the list the bench derived from the requirements. The reset checks are timed the same way: in_ready must rise one edge after release.

// File: rtl/wpt_pkg.sv
// Shared constants and types for the three-level wavelet packet engine.
package wpt_pkg;
    localparam int TAG_W    = 3;
    localparam int L1_BANDS = 2;
    localparam int L2_BANDS = 2 * L1_BANDS;
    localparam int SEL_W    = $clog2(L2_BANDS);

    // Level-2 band selector code: {level-1 band, level-2 band}.
    typedef enum logic [SEL_W-1:0] {
        BAND_LL = 2'b00,
        BAND_LH = 2'b01,
        BAND_HL = 2'b10,
        BAND_HH = 2'b11
    } l2_band_e;
endpackage

// File: rtl/wpt_butterfly.sv
// Haar butterfly: average and half-difference of a sample pair.
// Assumes two's complement inputs. The sum and difference are one bit wider
// than the data, and the 1/2 scale is a one-digit CSD term (a shift).
module wpt_butterfly #(
    parameter int DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] a_i,
    input  logic signed [DATA_W-1:0] b_i,
    output logic signed [DATA_W-1:0] avg_o,
    output logic signed [DATA_W-1:0] dif_o
);
    localparam int XW = DATA_W + 1;

    logic signed [XW-1:0] sum_x;
    logic signed [XW-1:0] dif_x;
    logic                 unused_lsbs;

    // Widened add and subtract, then drop the LSB (arithmetic shift by one).
    always_comb begin
        sum_x       = {a_i[DATA_W-1], a_i} + {b_i[DATA_W-1], b_i};
        dif_x       = {a_i[DATA_W-1], a_i} - {b_i[DATA_W-1], b_i};
        avg_o       = sum_x[XW-1:1];
        dif_o       = dif_x[XW-1:1];
        unused_lsbs = sum_x[0] ^ dif_x[0];
    end
endmodule

// File: rtl/wpt_pair_stage.sv
// One decomposition stage: pairs consecutive valid samples (even, odd).
// Registers low and high results when the odd sample arrives.
// A sample flagged sof is always taken as even. The sof of the even sample
// and the last flag of the odd sample travel with the output.
module wpt_pair_stage #(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sof,
    input  logic                     in_last,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic                     out_sof,
    output logic                     out_last,
    output logic signed [DATA_W-1:0] out_lo,
    output logic signed [DATA_W-1:0] out_hi
);
    logic                     odd_q;
    logic                     even_sof_q;
    logic signed [DATA_W-1:0] even_q;
    logic                     take_even;
    logic                     take_odd;
    logic signed [DATA_W-1:0] bf_avg;
    logic signed [DATA_W-1:0] bf_dif;

    assign take_even = in_valid && (in_sof || !odd_q);
    assign take_odd  = in_valid && odd_q && !in_sof;

    wpt_butterfly #(.DATA_W(DATA_W)) u_bf (
        .a_i  (even_q),
        .b_i  (in_data),
        .avg_o(bf_avg),
        .dif_o(bf_dif)
    );

    // Phase: next valid sample is odd only right after an even one.
    always_ff @(posedge clk) begin
        if (!rst_n)        odd_q <= 1'b0;
        else if (in_valid) odd_q <= take_even;
    end

    // Hold the even sample and its frame-start flag.
    always_ff @(posedge clk) begin
        if (take_even) begin
            even_q     <= in_data;
            even_sof_q <= in_sof;
        end
    end

    // Output valid strobe, one per completed pair.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= take_odd;
    end

    // Register the pair results and the flags that travel with them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sof  <= 1'b0;
            out_last <= 1'b0;
        end else if (take_odd) begin
            out_sof  <= even_sof_q;
            out_last <= in_last;
        end
    end

    always_ff @(posedge clk) begin
        if (take_odd) begin
            out_lo <= bf_avg;
            out_hi <= bf_dif;
        end
    end

    // R2: a pair needs two samples, so results never come on adjacent cycles.
    a_r2_pair_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: rtl/wpt_band_bank.sv
// Level-2 register bank with the shared level-3 filter.
// Collects an even and an odd value for each of the four level-2 bands.
// On the odd capture it copies both into a hold bank, then steps a 4-way
// selector over the bands on consecutive cycles. One butterfly serves all.
// Assumes a new odd capture never comes while the selector is still running
// (true at one input sample per cycle or slower).
module wpt_band_bank
    import wpt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cap_valid,
    input  logic                               cap_sof,
    input  logic                               cap_last,
    input  logic [L2_BANDS-1:0][DATA_W-1:0]    cap_data,
    output logic                               out_valid,
    output logic [SEL_W-1:0]                   out_band,
    output logic signed [DATA_W-1:0]           out_lo,
    output logic signed [DATA_W-1:0]           out_hi,
    output logic                               out_eof
);
    localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(L2_BANDS - 1);

    logic                            odd_q;
    logic [L2_BANDS-1:0][DATA_W-1:0] even_q;
    logic [L2_BANDS-1:0][DATA_W-1:0] hold_a_q;
    logic [L2_BANDS-1:0][DATA_W-1:0] hold_b_q;
    logic                            grp_last_q;
    logic                            busy_q;
    logic [SEL_W-1:0]                sel_q;
    logic                            eof_pend_q;
    logic                            take_even;
    logic                            take_odd;
    logic signed [DATA_W-1:0]        mux_a;
    logic signed [DATA_W-1:0]        mux_b;
    logic signed [DATA_W-1:0]        bf_avg;
    logic signed [DATA_W-1:0]        bf_dif;

    assign take_even = cap_valid && (cap_sof || !odd_q);
    assign take_odd  = cap_valid && odd_q && !cap_sof;

    // 4-to-1 selector in front of the shared level-3 filter.
    assign mux_a = hold_a_q[sel_q];
    assign mux_b = hold_b_q[sel_q];

    wpt_butterfly #(.DATA_W(DATA_W)) u_bf3 (
        .a_i  (mux_a),
        .b_i  (mux_b),
        .avg_o(bf_avg),
        .dif_o(bf_dif)
    );

    // Level-3 phase for the four bands (they move in lockstep).
    always_ff @(posedge clk) begin
        if (!rst_n)         odd_q <= 1'b0;
        else if (cap_valid) odd_q <= take_even;
    end

    // Even values of the four bands.
    always_ff @(posedge clk) begin
        if (take_even) even_q <= cap_data;
    end

    // Hold bank loaded on the odd capture.
    always_ff @(posedge clk) begin
        if (take_odd) begin
            hold_a_q <= even_q;
            hold_b_q <= cap_data;
        end
    end

    // Selector sequencer: runs 0..3 once after each odd capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            sel_q      <= '0;
            grp_last_q <= 1'b0;
        end else if (take_odd) begin
            busy_q     <= 1'b1;
            sel_q      <= '0;
            grp_last_q <= cap_last;
        end else if (busy_q) begin
            sel_q <= sel_q + 1'b1;
            if (sel_q == SEL_LAST) busy_q <= 1'b0;
        end
    end

    // Output coefficient registers.
    always_ff @(posedge clk) begin
        if (busy_q) begin
            out_lo   <= bf_avg;
            out_hi   <= bf_dif;
            out_band <= sel_q;
        end
    end

    // Valid strobe and end-of-frame, one cycle after the final band.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            eof_pend_q <= 1'b0;
            out_eof    <= 1'b0;
        end else begin
            out_valid  <= busy_q;
            eof_pend_q <= busy_q && (sel_q == SEL_LAST) && grp_last_q;
            out_eof    <= eof_pend_q;
        end
    end

    // R5: once started, the selector steps by one each cycle until band 3.
    a_r5_sel_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && sel_q != SEL_LAST) |=> (busy_q && sel_q == $past(sel_q) + 1'b1));

    // R6: the shared filter is never asked to start while still serving a group.
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        take_odd |-> !busy_q);
endmodule

// File: rtl/wpt_haar3.sv
// Top of the three-level wavelet packet engine.
// Level 1 is one pair stage. Level 2 is two pair stages, one per level-1
// band. Level 3 is a register bank with a time-shared filter pair.
// Always ready after reset: at most one sample per cycle never backs up.
module wpt_haar3
    import wpt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic                     in_sof,
    input  logic                     in_last,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_lo_data,
    output logic [TAG_W-1:0]         out_lo_tag,
    output logic signed [DATA_W-1:0] out_hi_data,
    output logic [TAG_W-1:0]         out_hi_tag,
    output logic                     out_eof
);
    logic                            accept;
    logic                            l1_valid;
    logic                            l1_sof;
    logic                            l1_last;
    logic [L1_BANDS-1:0][DATA_W-1:0] l1_band;
    logic [L1_BANDS-1:0]             l2_valid;
    logic [L1_BANDS-1:0]             l2_sof;
    logic [L1_BANDS-1:0]             l2_last;
    logic [L2_BANDS-1:0][DATA_W-1:0] l2_band;
    logic [SEL_W-1:0]                band_sel;

    // Ready register: low in reset, high afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    assign accept = in_valid && in_ready;

    wpt_pair_stage #(.DATA_W(DATA_W)) u_lvl1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (accept),
        .in_sof   (in_sof),
        .in_last  (in_last),
        .in_data  (in_data),
        .out_valid(l1_valid),
        .out_sof  (l1_sof),
        .out_last (l1_last),
        .out_lo   (l1_band[0]),
        .out_hi   (l1_band[1])
    );

    // One level-2 stage per level-1 band; band index = {g, low/high}.
    for (genvar g = 0; g < L1_BANDS; g++) begin : g_lvl2
        wpt_pair_stage #(.DATA_W(DATA_W)) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (l1_valid),
            .in_sof   (l1_sof),
            .in_last  (l1_last),
            .in_data  (l1_band[g]),
            .out_valid(l2_valid[g]),
            .out_sof  (l2_sof[g]),
            .out_last (l2_last[g]),
            .out_lo   (l2_band[2*g]),
            .out_hi   (l2_band[2*g+1])
        );
    end

    wpt_band_bank #(.DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_valid(l2_valid[0]),
        .cap_sof  (l2_sof[0]),
        .cap_last (l2_last[0]),
        .cap_data (l2_band),
        .out_valid(out_valid),
        .out_band (band_sel),
        .out_lo   (out_lo_data),
        .out_hi   (out_hi_data),
        .out_eof  (out_eof)
    );

    assign out_lo_tag = {band_sel, 1'b0};
    assign out_hi_tag = {band_sel, 1'b1};

    // R3: both level-2 stages complete their pairs on the same cycles.
    a_r3_lvl2_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ({l2_valid[0], l2_sof[0], l2_last[0]} ==
                  {l2_valid[1], l2_sof[1], l2_last[1]}));

    // R8: the frame strobe directly follows the band-3 output of the group.
    a_r8_eof_after_band3: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> ($past(out_valid) && $past(out_lo_tag) == 3'b110));
endmodule

// File: tb/sim_wpt_haar3.sv
module sim_wpt_haar3;
    localparam int W = 16;
    localparam int MAXE = 512;

    localparam logic signed [W-1:0] STIM_TAB [32] = '{
        16'sd10,    16'sd20,    16'sd30,    16'sd40,    16'sd50,    16'sd60,    16'sd70,    16'sd80,
        -16'sd5,    16'sd7,     -16'sd9,    16'sd11,    16'sd3,     -16'sd1,    16'sd0,     16'sd4,
        16'sd1000,  -16'sd999,  16'sd123,   16'sd321,   -16'sd77,   -16'sd78,   16'sd500,   -16'sd2,
        16'sd32767, -16'sd32768, 16'sd32767, -16'sd32768, -16'sd32768, -16'sd32768, 16'sd32767, 16'sd32767
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_sof = 1'b0;
    logic in_last = 1'b0;
    logic signed [W-1:0] in_data = '0;
    logic in_ready;
    logic out_valid;
    logic signed [W-1:0] out_lo_data;
    logic signed [W-1:0] out_hi_data;
    logic [2:0] out_lo_tag;
    logic [2:0] out_hi_tag;
    logic out_eof;

    always #4 clk = ~clk;

    wpt_haar3 #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_last(in_last), .in_data(in_data),
        .out_valid(out_valid), .out_lo_data(out_lo_data), .out_lo_tag(out_lo_tag),
        .out_hi_data(out_hi_data), .out_hi_tag(out_hi_tag), .out_eof(out_eof)
    );

    int n_edges = 0;
    always @(posedge clk) n_edges <= n_edges + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int    exp_edge [MAXE];
    int    exp_tag  [MAXE];
    int    exp_data [MAXE];
    string exp_req  [MAXE];
    int    n_exp = 0;
    int    log_edge [MAXE];
    int    log_tag  [MAXE];
    int    log_data [MAXE];
    int    n_log = 0;
    int    exp_eof [32];
    int    log_eof [32];
    int    n_exp_eof = 0;
    int    n_log_eof = 0;

    int grp [8];
    int grp_pos = 0;

    task automatic chk(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    // Output monitor: logs every coefficient and frame strobe with its edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && n_log + 2 <= MAXE) begin
                log_edge[n_log] = n_edges; log_tag[n_log] = int'(out_lo_tag);
                log_data[n_log] = int'(out_lo_data); n_log++;
                log_edge[n_log] = n_edges; log_tag[n_log] = int'(out_hi_tag);
                log_data[n_log] = int'(out_hi_data); n_log++;
            end
            if (out_eof && n_log_eof < 32) begin
                log_eof[n_log_eof] = n_edges; n_log_eof++;
            end
        end
    end

    task automatic push_exp(input int e, input int tag, input int val, input string req);
        if (n_exp < MAXE) begin
            exp_edge[n_exp] = e; exp_tag[n_exp] = tag;
            exp_data[n_exp] = val; exp_req[n_exp] = req; n_exp++;
        end
    endtask

    // Reference cascade from R2/R3; band s of a group ending at edge e is due at e+3+s (R6).
    task automatic add_group(input int e, input string req);
        int l1l [4];
        int l1h [4];
        int l2 [4][2];
        for (int p = 0; p < 4; p++) begin
            l1l[p] = (grp[2*p] + grp[2*p+1]) >>> 1;
            l1h[p] = (grp[2*p] - grp[2*p+1]) >>> 1;
        end
        for (int k = 0; k < 2; k++) begin
            l2[0][k] = (l1l[2*k] + l1l[2*k+1]) >>> 1;
            l2[1][k] = (l1l[2*k] - l1l[2*k+1]) >>> 1;
            l2[2][k] = (l1h[2*k] + l1h[2*k+1]) >>> 1;
            l2[3][k] = (l1h[2*k] - l1h[2*k+1]) >>> 1;
        end
        for (int s = 0; s < 4; s++) begin
            push_exp(e + 3 + s, 2*s,     (l2[s][0] + l2[s][1]) >>> 1, req);
            push_exp(e + 3 + s, 2*s + 1, (l2[s][0] - l2[s][1]) >>> 1, req);
        end
    endtask

    // Drive one sample at a falling edge; it is accepted on the next rising edge.
    task automatic drive(input int d, input bit sof, input bit last, input string req);
        int e;
        in_valid = 1'b1; in_sof = sof; in_last = last; in_data = W'(d);
        @(negedge clk);
        e = n_edges;
        in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0;
        if (sof) grp_pos = 0;
        grp[grp_pos] = d;
        grp_pos++;
        if (grp_pos == 8) begin
            add_group(e, req);
            grp_pos = 0;
        end
        if (last && n_exp_eof < 32) begin
            exp_eof[n_exp_eof] = e + 7; n_exp_eof++;
        end
    endtask

    // Idle cycles with junk on the data and flag pins (R9).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0; in_data = W'(16'h5A5A + i); in_sof = i[0]; in_last = i[1];
            @(negedge clk);
        end
        in_sof = 1'b0; in_last = 1'b0;
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 in_ready in reset", int'(in_ready), 0);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 out_eof in reset", int'(out_eof), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 in_ready after release", int'(in_ready), 1);

        // Table walk: one 32-sample frame; last group is full scale (R10).
        for (int i = 0; i < 32; i++)
            drive(int'(STIM_TAB[i]), i == 0, i == 31, (i >= 24) ? "R10" : "R3");
        // Back-to-back next frame: sof follows the previous last directly (R5, R7).
        for (int i = 0; i < 8; i++)
            drive(i * 37 - 100, i == 0, i == 7, "R5");
        idle(12);
        chk("R3 coefficient count after table", n_log, n_exp);

        // Gaps with junk data between samples (R9).
        for (int i = 0; i < 16; i++) begin
            drive(300 - i * i * 11, i == 0, i == 15, "R9");
            idle(i % 3);
        end
        idle(12);
        chk("R9 coefficient count with gaps", n_log, n_exp);

        // Partial group cut by a new frame start (R7).
        for (int i = 0; i < 6; i++)
            drive(777 + i, i == 0, 1'b0, "R7");
        for (int i = 0; i < 8; i++)
            drive(-40 + i * 9 - (i % 2) * 25, i == 0, i == 7, "R7");
        idle(12);
        chk("R7 no output from aborted group", n_log, n_exp);

        // Reset in the middle of a group (R1).
        for (int i = 0; i < 5; i++)
            drive(i + 1, i == 0, 1'b0, "R1");
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 in_ready mid-stream reset", int'(in_ready), 0);
        chk("R1 out_valid mid-stream reset", int'(out_valid), 0);
        @(negedge clk);
        chk("R1 out_eof mid-stream reset", int'(out_eof), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 in_ready after second release", int'(in_ready), 1);
        for (int i = 0; i < 8; i++)
            drive(-1000 + i * 250, i == 0, i == 7, "R2");
        idle(12);

        // Ordered comparison of everything logged.
        chk("R3 total coefficient count", n_log, n_exp);
        for (int i = 0; i < n_exp && i < n_log; i++) begin
            chk({exp_req[i], " coefficient value"}, log_data[i], exp_data[i]);
            chk("R4 sub-band tag", log_tag[i], exp_tag[i]);
            chk("R6 arrival edge", log_edge[i], exp_edge[i]);
        end
        chk("R8 end-of-frame count", n_log_eof, n_exp_eof);
        for (int i = 0; i < n_exp_eof && i < n_log_eof; i++)
            chk("R8 end-of-frame edge", log_eof[i], exp_eof[i]);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule